// File: doc/BRIEF.md
# Event Counter Bank with Saturating and Wrapping Banks

This block holds two banks of four 16-bit event counters for the back end of a serial bus terminal. The external bank counts rising edges on four event lines that arrive from outside the chip with no fixed timing. Each line passes through a two-flop synchronizer into the system clock domain, and the rising edge is detected there. An external counter stops at full scale. The internal bank counts rising edges on four event lines that the protocol logic drives in the system clock domain. Line 0 marks the start of each received command, line 1 marks each message that completed without error, and lines 2 and 3 are free for other event sources. An internal counter rolls over to zero instead of stopping.

The back end reads a bank through a word-indexed read port. It picks the bank and a word index, and the counter value appears combinationally on the data output. Stepping the index from 0 to 3 in one transaction returns the four counters of the bank as consecutive words. A one-cycle clear strobe per bank sets all four counters of that bank to zero at once. The bus write that triggers the clear carries data, and that data plays no part.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, every counter in both banks reads 0.
- R2: An external counter adds one for each low-to-high transition of its input. The new value is visible on the read port after the third rising clock edge that follows the input going high. An input held high counts only once.
- R3: An external counter that has reached 65535 stays at 65535 when further rising edges arrive.
- R4: An internal counter adds one for each low-to-high transition of its input. The new value is visible right after the first rising clock edge that samples the input high. Input bit 0 is the command-start event and bit 1 is the message-completed-OK event.
- R5: An internal counter at 65535 becomes 0 on its next counted event.
- R6: A high ext_clr_i at a clock edge sets all four external counters to 0, and a high int_clr_i sets all four internal counters to 0. Each clear leaves the other bank unchanged.
- R7: When a clear and a counted event land on the same clock edge, the clear takes effect and the counter becomes 0.
- R8: rd_data_o shows, combinationally, the counter chosen by rd_bank_i (0 = external, 1 = internal) and rd_idx_i (values 0 to 3 select counters 0 to 3).
- R9: rd_idx_i values 4 to 7 read 0 from either bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ext_evt_i | input | 4 | External event lines, asynchronous to clk |
| int_evt_i | input | 4 | Internal event lines, synchronous to clk (bit 0 command start, bit 1 message OK) |
| ext_clr_i | input | 1 | Clears all external counters |
| int_clr_i | input | 1 | Clears all internal counters |
| rd_bank_i | input | 1 | Bank select for the read port: 0 external, 1 internal |
| rd_idx_i | input | 3 | Word index for the read port |
| rd_data_o | output | 16 | Selected counter value, 0 for an out-of-range index |

## Verification
The assertions assume that int_evt_i, both clear strobes and the read selection change only in step with clk. Under that assumption a counter moves by at most one per cycle, either up by one or, in the external bank, holding at full scale, unless a clear is present. ext_evt_i may change at any time. The bench drives every input on the falling edge, so the synchronous inputs meet that assumption, and it toggles the external lines freely. A long phase toggles every line each cycle until the external counters saturate and the internal ones wrap.

// File: rtl/evt_counter_bank.sv
module evt_counter_bank #(
  parameter int CNT_W  = 16,
  parameter int N_CNT  = 4,
  parameter int SYNC_N = 2,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CNT-1:0] ext_evt_i,
  input  logic [N_CNT-1:0] int_evt_i,
  input  logic             ext_clr_i,
  input  logic             int_clr_i,
  input  logic             rd_bank_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o
);

  localparam int SEL_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [N_CNT-1:0][CNT_W-1:0] ext_cnt;
  logic [N_CNT-1:0][CNT_W-1:0] int_cnt;

  for (genvar g = 0; g < N_CNT; g++) begin : g_lane
    logic [SYNC_N-1:0] sync_q;
    logic              ext_prev_q;
    logic              int_prev_q;
    logic [CNT_W-1:0]  ext_q;
    logic [CNT_W-1:0]  int_q;
    logic              ext_rise;
    logic              int_rise;

    assign ext_rise = sync_q[SYNC_N-1] & ~ext_prev_q;
    assign int_rise = int_evt_i[g] & ~int_prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q     <= '0;
        ext_prev_q <= 1'b0;
        int_prev_q <= 1'b0;
      end else begin
        sync_q     <= {sync_q[SYNC_N-2:0], ext_evt_i[g]};
        ext_prev_q <= sync_q[SYNC_N-1];
        int_prev_q <= int_evt_i[g];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || ext_clr_i)            ext_q <= '0;
      else if (ext_rise && ext_q != FULL) ext_q <= ext_q + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || int_clr_i) int_q <= '0;
      else if (int_rise)       int_q <= int_q + 1'b1;
    end

    assign ext_cnt[g] = ext_q;
    assign int_cnt[g] = int_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_idx_i) < N_CNT)
      rd_data_o = rd_bank_i ? int_cnt[rd_idx_i[SEL_W-1:0]]
                            : ext_cnt[rd_idx_i[SEL_W-1:0]];
  end

endmodule

// File: rtl/evt_counter_bank_chk.sv
module evt_counter_bank_chk #(
  parameter int CNT_W = 16,
  parameter int N_CNT = 4,
  parameter int IDX_W = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ext_clr_i,
  input logic                        int_clr_i,
  input logic [IDX_W-1:0]            rd_idx_i,
  input logic [CNT_W-1:0]            rd_data_o,
  input logic [N_CNT-1:0][CNT_W-1:0] ext_cnt,
  input logic [N_CNT-1:0][CNT_W-1:0] int_cnt
);

  localparam logic [CNT_W-1:0] FULL = '1;

  AST_EXT_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clr_i |=> ext_cnt == '0); // R6

  AST_INT_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr_i |=> int_cnt == '0); // R6

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx_i) >= N_CNT) |-> rd_data_o == '0); // R9

  for (genvar g = 0; g < N_CNT; g++) begin : g_chk
    AST_EXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_clr_i |=> (ext_cnt[g] == $past(ext_cnt[g]) ||
                      ext_cnt[g] == $past(ext_cnt[g]) + 1'b1)); // R2

    AST_EXT_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_clr_i && ext_cnt[g] == FULL) |=> ext_cnt[g] == FULL); // R3

    AST_INT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !int_clr_i |=> (int_cnt[g] == $past(int_cnt[g]) ||
                      int_cnt[g] == $past(int_cnt[g]) + 1'b1)); // R5
  end

endmodule

bind evt_counter_bank evt_counter_bank_chk #(
  .CNT_W(CNT_W), .N_CNT(N_CNT), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/evt_counter_bank_tb.sv
module evt_counter_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ext_evt = '0;
  logic [3:0]  int_evt = '0;
  logic        ext_clr = 1'b0;
  logic        int_clr = 1'b0;
  logic        rd_bank = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int unsigned me [4];
  int unsigned mi [4];
  logic [3:0] d1 = '0, d2 = '0, d3 = '0;
  logic [3:0] w1 = '0;

  always #2.5 clk = ~clk;

  evt_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ext_evt_i(ext_evt), .int_evt_i(int_evt),
    .ext_clr_i(ext_clr), .int_clr_i(int_clr), .rd_bank_i(rd_bank),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  function automatic int unsigned model_read(input logic bk, input logic [2:0] ix);
    if (ix > 3) return 0;
    return bk ? mi[ix] : me[ix];
  endfunction

  task automatic check(input string tag, input int unsigned got, input int unsigned exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] e, input logic [3:0] w, input logic ec,
                      input logic ic, input logic bk, input logic [2:0] ix,
                      input bit chk, input string tag);
    @(negedge clk);
    ext_evt = e; int_evt = w; ext_clr = ec; int_clr = ic; rd_bank = bk; rd_idx = ix;
    #1;
    if (chk) check(tag, rd_data, model_read(bk, ix));
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (ec) me[i] = 0;
      else if (d2[i] && !d3[i] && me[i] < 65535) me[i] = me[i] + 1;
      if (ic) mi[i] = 0;
      else if (w[i] && !w1[i]) mi[i] = (mi[i] + 1) % 65536;
    end
    d3 = d2; d2 = d1; d1 = e; w1 = w;
  endtask

  task automatic read_all(input string tag);
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        rd_bank = b[0]; rd_idx = i[2:0];
        #1;
        check(tag, rd_data, model_read(b[0], i[2:0]));
      end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] e, w;
    void'($urandom(32'd1553));
    for (int i = 0; i < 4; i++) begin me[i] = 0; mi[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state, R9 out-of-range index
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); rd_bank = b[0]; rd_idx = i[2:0]; #1;
        check("R1 reset zero", rd_data, 0);
      end
    read_all("R9 out-of-range");

    // R2 latency and held-high counts once
    for (int k = 0; k < 6; k++) step(4'b0100, 4'b0000, 0, 0, 0, 3'd2, 1, "R2 ext latency");
    check("R2 ext single count", me[2], 1);
    step(4'b0000, 4'b0000, 0, 0, 0, 3'd2, 1, "R2 ext low");
    @(negedge clk); rd_bank = 0; rd_idx = 3'd2; #1;
    check("R2 ext value", rd_data, 1);

    // R4 internal command-start and message-OK events
    step(4'b0000, 4'b0001, 0, 0, 1, 3'd0, 1, "R4 cmd start");
    step(4'b0000, 4'b0001, 0, 0, 1, 3'd0, 1, "R4 cmd held");
    step(4'b0000, 4'b0010, 0, 0, 1, 3'd0, 1, "R4 cmd");
    step(4'b0000, 4'b0000, 0, 0, 1, 3'd1, 1, "R4 msg ok");
    @(negedge clk); rd_bank = 1; rd_idx = 3'd0; #1;
    check("R4 cmd count", rd_data, 1);
    rd_idx = 3'd1; #1;
    check("R4 msg ok count", rd_data, 1);

    // R6 clear one bank leaves the other
    step(4'b0000, 4'b0000, 1, 0, 0, 3'd0, 0, "R6");
    read_all("R6 ext clear");
    @(negedge clk); rd_bank = 1; rd_idx = 3'd1; #1;
    check("R6 int kept", rd_data, 1);
    step(4'b0000, 4'b0000, 0, 1, 1, 3'd1, 0, "R6");
    read_all("R6 int clear");

    // R7 clear against coincident event
    step(4'b0001, 4'b0000, 0, 0, 0, 3'd0, 0, "R7");
    step(4'b0001, 4'b0000, 0, 0, 0, 3'd0, 0, "R7");
    step(4'b0001, 4'b1000, 1, 1, 0, 3'd0, 0, "R7");
    @(negedge clk); rd_bank = 0; rd_idx = 3'd0; #1;
    check("R7 ext clear wins", rd_data, 0);
    rd_bank = 1; rd_idx = 3'd3; #1;
    check("R7 int clear wins", rd_data, 0);

    // R8 constrained random traffic
    for (int k = 0; k < 3000; k++) begin
      e = 4'($urandom);
      w = 4'($urandom);
      step(e, w, ($urandom % 64) == 0, ($urandom % 64) == 0,
           1'($urandom), 3'($urandom), 1, "R8 random read");
    end

    // R3 saturation and R5 wrap under continuous toggling
    step(4'b0000, 4'b0000, 1, 1, 0, 3'd0, 0, "R3");
    for (int k = 0; k < 131200; k++) begin
      e = k[0] ? 4'hF : 4'h0;
      step(e, e, 0, 0, k[1], 3'(k >> 2), (k % 4096) == 0, "R5 toggle");
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rd_bank = 0; rd_idx = i[2:0]; #1;
      check("R3 ext saturated", rd_data, 65535);
      rd_bank = 1; #1;
      check("R5 int wrapped", rd_data, mi[i]);
      check("R5 int wrapped low", (mi[i] < 200) ? 1 : 0, 1);
    end
    read_all("R8 final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule